// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block brings a 16-bit DDR SDRAM to a usable state once reset is released. It first waits out the power-up interval. It then sends a short chain of command words to the controller's command port, enables the refresh engine part way through, and reports completion so that normal read and write traffic may begin. Every wait is a cycle count. The counts are worked out at elaboration time from a clock-frequency parameter and a set of microsecond parameters, rounded upward, so no interval is ever shorter than its minimum.

The command port is a plain strobe interface. A command word is valid only in a cycle where the strobe is high, and the word is all zeros in every other cycle. There is no back-pressure: the downstream command port must accept a word in the cycle it is presented. The refresh enable, busy and done outputs are plain level signals.

The chain runs in this order:
1. power-up wait
2. precharge-all
3. extended-mode load
4. mode load with DLL reset
5. second precharge-all, then refresh on
6. refresh wait
7. mode load without DLL reset
8. DLL settle wait, then done

Top module: `ddr_powerup_seq`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `cmd_word` = 0, `cmd_strobe` = 0, `refresh_on` = 0, `busy` = 1, `done` = 0.
- R2: Counting the first rising clock edge with `rst_n` high as edge 1, the first command (precharge-all, 0x8000) is presented after edge Dp, where Dp = ceil(T_POWERUP_US · CLK_HZ / 1e6).
- R3: Commands two to four follow the previous command by exactly Dc = ceil(T_CMD_US · CLK_HZ / 1e6) cycles each. They are, in order: extended-mode load 0x2000, mode load 0x0121, precharge-all 0x8000.
- R4: Each command is presented for exactly one cycle with `cmd_strobe` high. In every cycle with `cmd_strobe` low, `cmd_word` is 0.
- R5: `refresh_on` rises in the cycle after the fourth command and stays high until the next reset.
- R6: The fifth command, a mode load with DLL reset cleared (0x0021), is presented exactly Dr = ceil(T_REFRESH_US · CLK_HZ / 1e6) cycles after `refresh_on` rises.
- R7: `done` rises Dd = ceil(T_DLL_US · CLK_HZ / 1e6) cycles after the fifth command, and `busy` falls in the same cycle. `done` then stays high and no further command is issued until reset.
- R8: Exactly five commands are issued per run.
- R9: A reset at any point, including after refresh has been enabled, returns all outputs to their R1 values. On release, the whole sequence repeats from the power-up wait with the timing of R2 to R7.
- R10: Command word fields:
  - Bit 15 set selects precharge-all.
  - Bit 13 set selects the extended mode load. Its bit 0 = 0 means DLL enabled, and its bit 1 = 0 means normal drive.
  - A mode load has bits 15 and 13 clear, with these fields: bits [2:0] burst-length code 1 (length 2), bit 3 = 0 (sequential), bits [6:4] CAS code 2, bit 8 = DLL reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts the sequence |
| cmd_word | output | 16 | Command word to the controller's command port, zero when idle |
| cmd_strobe | output | 1 | One-cycle write strobe qualifying `cmd_word` |
| refresh_on | output | 1 | Enables the downstream auto-refresh engine |
| busy | output | 1 | High from reset until the sequence completes |
| done | output | 1 | Sticky completion flag; memory ready for accesses |

## Verification
The hardest case to reach from the ports is a reset that lands after refresh has been enabled but before the final mode load. In that case `refresh_on` must drop, and the restarted run must again wait the full power-up interval instead of resuming mid-chain. The stimulus runs one sequence to past the refresh rise, pulls reset for a few cycles, and checks the R1 values. It then records a complete second run cycle by cycle and compares every strobe position, word, refresh edge and done edge against counts computed from the microsecond parameters.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  // Command word field positions (decoded by the command port downstream)
  localparam int unsigned PRECH_BIT   = 15;
  localparam int unsigned EXT_SEL_BIT = 13;
  localparam int unsigned DLL_RST_BIT = 8;
  localparam int unsigned CAS_LSB     = 4;
  localparam int unsigned BT_BIT      = 3;
  localparam int unsigned BL_LSB      = 0;
  localparam int unsigned EXT_DRV_BIT = 1;
  localparam int unsigned EXT_DLL_BIT = 0;

  localparam int unsigned NUM_CMDS     = 5;
  localparam int unsigned REFRESH_STEP = 4;  // step index reached after 4th command

  typedef enum logic {ST_RUN, ST_FIN} seq_state_e;

  // Microseconds to clock cycles, rounded up
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input longint unsigned clk_hz);
    longint unsigned prod;
    prod = longint'(us) * clk_hz;
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/dinit_timer.sv
module dinit_timer #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RST_VAL;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dinit_step_rom.sv
module dinit_step_rom
  import dinit_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned STEP_W   = 3,
  parameter int unsigned D_PWR    = 10000,
  parameter int unsigned D_CMD    = 50,
  parameter int unsigned D_REF    = 1501,
  parameter int unsigned D_DLL    = 100,
  parameter int unsigned BL_CODE  = 1,
  parameter int unsigned CAS_CODE = 2,
  parameter bit          BT_ILV   = 1'b0,
  parameter bit          DRV_RED  = 1'b0
) (
  input  logic [STEP_W-1:0] cmd_idx,
  input  logic [STEP_W-1:0] wait_idx,
  output logic [15:0]       word,
  output logic [CNT_W-1:0]  delay_m1
);

  localparam logic [15:0] W_PRE = 16'h1 << PRECH_BIT;
  localparam logic [15:0] W_EXT = (16'h1 << EXT_SEL_BIT)
                                | (16'(DRV_RED) << EXT_DRV_BIT)
                                | (16'h0 << EXT_DLL_BIT);
  localparam logic [15:0] W_MODE = (16'(CAS_CODE & 7) << CAS_LSB)
                                 | (16'(BT_ILV) << BT_BIT)
                                 | (16'(BL_CODE & 7) << BL_LSB);
  localparam logic [15:0] W_MODE_RST = W_MODE | (16'h1 << DLL_RST_BIT);

  always_comb begin
    case (cmd_idx)
      STEP_W'(0), STEP_W'(3): word = W_PRE;
      STEP_W'(1):             word = W_EXT;
      STEP_W'(2):             word = W_MODE_RST;
      STEP_W'(4):             word = W_MODE;
      default:                word = '0;
    endcase
  end

  always_comb begin
    case (wait_idx)
      STEP_W'(0): delay_m1 = CNT_W'(D_PWR - 1);
      STEP_W'(1), STEP_W'(2), STEP_W'(3): delay_m1 = CNT_W'(D_CMD - 1);
      STEP_W'(4): delay_m1 = CNT_W'(D_REF - 1);
      STEP_W'(5): delay_m1 = CNT_W'(D_DLL - 1);
      default:    delay_m1 = '0;
    endcase
  end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import dinit_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned T_POWERUP_US = 200,
  parameter int unsigned T_CMD_US     = 1,
  parameter int unsigned T_REFRESH_US = 30,
  parameter int unsigned T_DLL_US     = 2,
  parameter int unsigned BL_CODE      = 1,
  parameter int unsigned CAS_CODE     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] cmd_word,
  output logic        cmd_strobe,
  output logic        refresh_on,
  output logic        busy,
  output logic        done
);

  localparam int unsigned D_PWR = us_to_cycles(T_POWERUP_US, longint'(CLK_HZ));
  localparam int unsigned D_CMD = us_to_cycles(T_CMD_US, longint'(CLK_HZ));
  // one extra cycle: the refresh wait is counted from the cycle refresh_on rises
  localparam int unsigned D_REF = us_to_cycles(T_REFRESH_US, longint'(CLK_HZ)) + 1;
  localparam int unsigned D_DLL = us_to_cycles(T_DLL_US, longint'(CLK_HZ));
  localparam int unsigned D_M1  = (D_PWR > D_CMD) ? D_PWR : D_CMD;
  localparam int unsigned D_M2  = (D_REF > D_DLL) ? D_REF : D_DLL;
  localparam int unsigned D_MAX = (D_M1 > D_M2) ? D_M1 : D_M2;
  localparam int unsigned CNT_W = $clog2(D_MAX + 1);
  localparam int unsigned STEP_W = $clog2(NUM_CMDS + 2);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_nxt;
  logic              expired;
  logic              advance;
  logic              load;
  logic [15:0]       rom_word;
  logic [CNT_W-1:0]  rom_delay;

  assign step_nxt = step + 1'b1;
  assign advance  = (state == ST_RUN) && expired;
  assign load     = advance && (step != STEP_W'(NUM_CMDS));

  dinit_step_rom #(
    .CNT_W(CNT_W), .STEP_W(STEP_W),
    .D_PWR(D_PWR), .D_CMD(D_CMD), .D_REF(D_REF), .D_DLL(D_DLL),
    .BL_CODE(BL_CODE), .CAS_CODE(CAS_CODE), .BT_ILV(1'b0), .DRV_RED(1'b0)
  ) u_rom (
    .cmd_idx  (step),
    .wait_idx (step_nxt),
    .word     (rom_word),
    .delay_m1 (rom_delay)
  );

  dinit_timer #(
    .CNT_W(CNT_W), .RST_VAL(CNT_W'(D_PWR - 1))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (rom_delay),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      step       <= '0;
      cmd_word   <= '0;
      cmd_strobe <= 1'b0;
      refresh_on <= 1'b0;
      busy       <= 1'b1;
      done       <= 1'b0;
    end else begin
      cmd_word   <= '0;
      cmd_strobe <= 1'b0;
      refresh_on <= refresh_on | (step >= STEP_W'(REFRESH_STEP));
      if (advance) begin
        if (step == STEP_W'(NUM_CMDS)) begin
          state <= ST_FIN;
          busy  <= 1'b0;
          done  <= 1'b1;
        end else begin
          cmd_word   <= rom_word;
          cmd_strobe <= 1'b1;
          step       <= step_nxt;
        end
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe); // R4
  AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |-> (cmd_word == 16'h0)); // R4
  AST_CMD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_strobe) |-> $past(expired)); // R3
  AST_REFRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_on |=> refresh_on); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R7
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_strobe && !busy)); // R7
  AST_DONE_NEEDS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> refresh_on); // R6

endmodule

// File: tb/ddr_powerup_seq_test.sv
module ddr_powerup_seq_test;

  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned WATCHDOG = 150_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word;
  logic        cmd_strobe;
  logic        refresh_on;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // recorded observations of one run
  int          n_strobe;
  int          s_at   [8];
  logic [15:0] s_word [8];
  int          ref_rise, done_at, idle_bad, pulse_bad, ref_drop, busy_bad, after_bad;

  always #10 clk = ~clk;

  ddr_powerup_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
    .refresh_on(refresh_on), .busy(busy), .done(done)
  );

  function automatic int cyc(input int us);
    return (us * (CLK_HZ / 1_000_000));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // rst_n already released at a negedge; observe n cycles
  task automatic observe(input int n);
    bit prev_s;
    n_strobe = 0; ref_rise = 0; done_at = 0; idle_bad = 0; pulse_bad = 0;
    ref_drop = 0; busy_bad = 0; after_bad = 0; prev_s = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (cmd_strobe) begin
        if (n_strobe < 8) begin s_at[n_strobe] = i; s_word[n_strobe] = cmd_word; end
        n_strobe++;
        if (prev_s) pulse_bad++;
      end else if (cmd_word != 16'h0) idle_bad++;
      prev_s = cmd_strobe;
      if (refresh_on && ref_rise == 0) ref_rise = i;
      if (ref_rise != 0 && !refresh_on) ref_drop++;
      if (done && done_at == 0) done_at = i;
      if (done_at == 0 && !busy) busy_bad++;
      if (done_at != 0 && (!done || busy || cmd_strobe)) after_bad++;
    end
  endtask

  task automatic check_run(input string tag);
    int t [5];
    logic [15:0] w [5];
    t[0] = cyc(200);
    t[1] = t[0] + cyc(1);
    t[2] = t[1] + cyc(1);
    t[3] = t[2] + cyc(1);
    t[4] = t[3] + 1 + cyc(30);
    w[0] = 16'h8000; w[1] = 16'h2000; w[2] = 16'h0121; w[3] = 16'h8000; w[4] = 16'h0021;
    chk({tag, " R8"}, "command count", n_strobe, 5);
    for (int k = 0; k < 5; k++) begin
      if (k < n_strobe) begin
        chk(k == 0 ? {tag, " R2"} : (k == 4 ? {tag, " R6"} : {tag, " R3"}),
            $sformatf("cmd%0d cycle", k), s_at[k], t[k]);
        chk({tag, " R10"}, $sformatf("cmd%0d word", k), s_word[k], w[k]);
      end
    end
    chk({tag, " R4"}, "nonzero idle words", idle_bad, 0);
    chk({tag, " R4"}, "strobe longer than one cycle", pulse_bad, 0);
    chk({tag, " R5"}, "refresh rise cycle", ref_rise, t[3] + 1);
    chk({tag, " R5"}, "refresh drops", ref_drop, 0);
    chk({tag, " R6"}, "refresh to cmd5 gap", t[4] - ref_rise, cyc(30));
    chk({tag, " R7"}, "done cycle", done_at, t[4] + cyc(2));
    chk({tag, " R7"}, "busy low early", busy_bad, 0);
    chk({tag, " R7"}, "activity after done", after_bad, 0);
  endtask

  task automatic check_reset_vals(input string tag);
    chk({tag, " R1"}, "cmd_word", cmd_word, 0);
    chk({tag, " R1"}, "cmd_strobe", cmd_strobe, 0);
    chk({tag, " R1"}, "refresh_on", refresh_on, 0);
    chk({tag, " R1"}, "busy", busy, 1);
    chk({tag, " R1"}, "done", done, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_vals("reset");
  endtask

  task automatic t_full_sequence();
    rst_n = 1'b1;
    observe(cyc(236) + 300);  // past done, covers sticky window
    check_run("full");
  endtask

  task automatic t_restart_after_refresh();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_vals("R9 pre");
    rst_n = 1'b1;
    observe(cyc(203) + 150);  // refresh has risen, fifth command not yet sent
    chk("R9", "refresh before mid reset", refresh_on, 1);
    chk("R9", "done before mid reset", done, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_vals("R9 mid");
    rst_n = 1'b1;
    observe(cyc(236) + 100);
    check_run("R9 rerun");
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt >= WATCHDOG && !finished) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cnt, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_full_sequence();
    t_restart_after_refresh();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule